// File: doc/BRIEF.md
# Sparse On-Demand Paged Memory

This block answers loads and stores across a wide address window while holding real storage only for the 4096-byte pages that software has actually written with something other than zero. A small pool of physical frames sits behind a fully associative table that maps page numbers to frames. A page that has never been given a frame behaves as zero memory: reads of it return zero and allocate nothing.

A store to a page with no frame takes the next free frame only if the stored bytes are nonzero and the byte budget still has room. The new frame reads as zero everywhere except at the bytes just written. A store that cannot get a frame is dropped without any indication. Frames are handed out in rising index order and are never released one at a time. A synchronous reset forgets every mapping and empties the budget.

The request side is a plain one-beat bus. Every request is taken in the cycle it is presented. A response strobe and the read data come back on the next cycle. Accesses are 1, 2, 4 or 8 bytes wide and little-endian, and they must be aligned to their own size. That alignment keeps every access inside one page and one 64-bit storage word.

Top module: `sparse_page_mem`

## Requirements
- R1: Bits 11:0 of the address are the offset inside a page and the bits above them are the page number. Accesses at the same offset in two different pages use separate storage, and a page number anywhere in the address window can be mapped.
- R2: A read of a page that has no frame returns all-zero data and allocates nothing.
- R3: A store to a page with no frame allocates a frame only when the bytes in use plus 4096 are strictly less than the smaller of MAX_BYTES and FRAMES×4096. Each allocation adds exactly 4096 to the bytes in use.
- R4: A store of all-zero data to a page with no frame allocates nothing, and later reads of that page return zero.
- R5: A newly allocated frame reads as zero at every byte the allocating store did not write. This holds even when the frame held data before a reset.
- R6: A nonzero store to a page with no frame is discarded when the budget in R3 refuses it, and later reads of that page return zero.
- R7: req_size selects the access width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. Data is little-endian. The byte at the request address appears in rsp_rdata[7:0], and the bits above the access width read as zero.
- R8: A store to a page that has a frame changes only the addressed bytes. This includes stores of zero data.
- R9: An access whose address is not a multiple of its width is ignored. Such a read returns zero, and such a store changes no data and allocates nothing.
- R10: Reset removes every page mapping and clears the bytes in use, so every allocation is available again afterwards.
- R11: rsp_ready is high in the cycle after each accepted request and low otherwise. rsp_rdata is registered with it, and rsp_rdata is zero for a store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_addr | input | ADDR_W | Byte address inside the window |
| req_size | input | 2 | Access width code (0:1, 1:2, 2:4, 3:8 bytes) |
| req_wdata | input | 64 | Store data, right-aligned |
| rsp_ready | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 64 | Load data, right-aligned and zero-extended |

## Verification
The bench builds the block with FRAMES=4 and MAX_BYTES=12288. With those values the byte budget runs out before the frame pool does, so a refused allocation is reached after only two pages. The strict "less than" rule can be seen at exactly the point where the bytes in use plus one page would equal the limit. Running a reset after the budget is spent and then allocating again shows the cleared budget. It also shows that a reused frame with stale data from before the reset still reads as zero. Page numbers near the top of the 32-bit window are used to show that the whole window can be mapped.

// File: rtl/spm_pkg.sv
package spm_pkg;
    localparam int PAGE_SHIFT = 12;
    localparam int PAGE_BYTES = 1 << PAGE_SHIFT;
    localparam int LANE_W     = 3;
    localparam int WORD_IDX_W = PAGE_SHIFT - LANE_W;
    localparam int WORDS_PER_PAGE = 1 << WORD_IDX_W;

    typedef enum logic [1:0] {
        SZ_B1 = 2'd0,
        SZ_B2 = 2'd1,
        SZ_B4 = 2'd2,
        SZ_B8 = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic                  write;
        logic [WORD_IDX_W-1:0] word;
        logic [LANE_W-1:0]     lane;
        acc_size_e             size;
    } acc_t;

    function automatic logic size_aligned(logic [LANE_W-1:0] lane, acc_size_e sz);
        case (sz)
            SZ_B1:   return 1'b1;
            SZ_B2:   return lane[0] == 1'b0;
            SZ_B4:   return lane[1:0] == 2'b00;
            default: return lane == 3'b000;
        endcase
    endfunction

    function automatic logic [7:0] size_lanes(acc_size_e sz);
        case (sz)
            SZ_B1:   return 8'h01;
            SZ_B2:   return 8'h03;
            SZ_B4:   return 8'h0F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [63:0] lanes_to_bits(logic [7:0] be);
        logic [63:0] m;
        for (int b = 0; b < 8; b++) m[b*8 +: 8] = {8{be[b]}};
        return m;
    endfunction
endpackage

// File: rtl/spm_tag_table.sv
module spm_tag_table #(
    parameter int FRAMES = 8,
    parameter int PN_W   = 20,
    parameter int FI_W   = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PN_W-1:0] lk_page,
    input  logic            ins_en,
    input  logic [FI_W-1:0] ins_frame,
    output logic [FRAMES-1:0] match_vec,
    output logic            hit,
    output logic [FI_W-1:0] hit_frame
);
    logic [FRAMES-1:0] valid_q;
    logic [PN_W-1:0]   tag_q [FRAMES];

    for (genvar i = 0; i < FRAMES; i++) begin : g_cmp
        assign match_vec[i] = valid_q[i] && (tag_q[i] == lk_page);
    end

    assign hit = |match_vec;

    always_comb begin
        hit_frame = '0;
        for (int i = 0; i < FRAMES; i++) begin
            if (match_vec[i]) hit_frame = hit_frame | FI_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (ins_en) begin
            valid_q[ins_frame] <= 1'b1;
            tag_q[ins_frame]   <= lk_page;
        end
    end
endmodule

// File: rtl/spm_frame_store.sv
module spm_frame_store
    import spm_pkg::*;
#(
    parameter int FRAMES = 8,
    parameter int FI_W   = 3
) (
    input  logic                  clk,
    input  logic                  alloc_en,
    input  logic                  wr_en,
    input  logic [FI_W-1:0]       frame,
    input  logic [WORD_IDX_W-1:0] word,
    input  logic [7:0]            be,
    input  logic [63:0]           wdata,
    output logic [63:0]           rdata
);
    localparam int DEPTH = FRAMES * WORDS_PER_PAGE;
    localparam int MA_W  = FI_W + WORD_IDX_W;

    logic [63:0]               mem [DEPTH];
    logic [WORDS_PER_PAGE-1:0] touched_q [FRAMES];
    logic [MA_W-1:0]           maddr;
    logic                      word_live;
    logic [63:0]               old_word, bmask, merged;

    assign maddr     = {frame, word};
    assign word_live = touched_q[frame][word];
    assign rdata     = word_live ? mem[maddr] : 64'd0;
    assign old_word  = (word_live && !alloc_en) ? mem[maddr] : 64'd0;
    assign bmask     = lanes_to_bits(be);
    assign merged    = (old_word & ~bmask) | (wdata & bmask);

    always_ff @(posedge clk) begin
        if (alloc_en) touched_q[frame] <= '0;
        if (wr_en) begin
            touched_q[frame][word] <= 1'b1;
            mem[maddr]             <= merged;
        end
    end
endmodule

// File: rtl/sparse_page_mem.sv
module sparse_page_mem
    import spm_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          FRAMES    = 8,
    parameter logic [63:0] MAX_BYTES = 64'd10485760
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [63:0]       req_wdata,
    output logic              rsp_ready,
    output logic [63:0]       rsp_rdata
);
    localparam int          PN_W       = ADDR_W - PAGE_SHIFT;
    localparam int          FI_W       = (FRAMES > 1) ? $clog2(FRAMES) : 1;
    localparam int          CNT_W      = $clog2(FRAMES + 1);
    localparam logic [63:0] POOL_BYTES = 64'(FRAMES) << PAGE_SHIFT;
    localparam logic [63:0] LIMIT      = (MAX_BYTES < POOL_BYTES) ? MAX_BYTES : POOL_BYTES;

    acc_t              acc;
    logic [PN_W-1:0]   page;
    logic [5:0]        bit_sh;
    logic              accepted, store_data_nz, budget_ok, do_alloc, do_write;
    logic [7:0]        be;
    logic [63:0]       wdata_sh, word_rd, load_val;
    logic [FRAMES-1:0] match_vec;
    logic              hit;
    logic [FI_W-1:0]   hit_frame, tgt_frame;
    logic [CNT_W-1:0]  pages_q;

    assign acc.write = req_write;
    assign acc.word  = req_addr[PAGE_SHIFT-1:LANE_W];
    assign acc.lane  = req_addr[LANE_W-1:0];
    assign acc.size  = acc_size_e'(req_size);
    assign page      = req_addr[ADDR_W-1:PAGE_SHIFT];
    assign bit_sh    = {acc.lane, 3'b000};

    assign accepted      = req_valid && size_aligned(acc.lane, acc.size);
    assign be            = 8'(size_lanes(acc.size) << acc.lane);
    assign wdata_sh      = req_wdata << bit_sh;
    assign store_data_nz = |(wdata_sh & lanes_to_bits(be));
    assign budget_ok     = ((64'(pages_q) + 64'd1) << PAGE_SHIFT) < LIMIT;
    assign do_alloc      = accepted && acc.write && !hit && store_data_nz && budget_ok;
    assign do_write      = accepted && acc.write && (hit || do_alloc);
    assign tgt_frame     = hit ? hit_frame : pages_q[FI_W-1:0];

    spm_tag_table #(.FRAMES(FRAMES), .PN_W(PN_W), .FI_W(FI_W)) u_tags (
        .clk       (clk),
        .rst       (rst),
        .lk_page   (page),
        .ins_en    (do_alloc),
        .ins_frame (pages_q[FI_W-1:0]),
        .match_vec (match_vec),
        .hit       (hit),
        .hit_frame (hit_frame)
    );

    spm_frame_store #(.FRAMES(FRAMES), .FI_W(FI_W)) u_store (
        .clk      (clk),
        .alloc_en (do_alloc),
        .wr_en    (do_write),
        .frame    (tgt_frame),
        .word     (acc.word),
        .be       (be),
        .wdata    (wdata_sh),
        .rdata    (word_rd)
    );

    assign load_val = (word_rd >> bit_sh) & lanes_to_bits(size_lanes(acc.size));

    always_ff @(posedge clk) begin
        if (rst) begin
            pages_q   <= '0;
            rsp_ready <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            if (do_alloc) pages_q <= pages_q + 1'b1;
            rsp_ready <= req_valid;
            rsp_rdata <= (accepted && !acc.write && hit) ? load_val : 64'd0;
        end
    end
endmodule

// File: rtl/spm_checker.sv
module spm_checker #(
    parameter int          ADDR_W = 32,
    parameter int          FRAMES = 8,
    parameter int          CNT_W  = 4,
    parameter logic [63:0] LIMIT  = 64'd32768
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic              rsp_ready,
    input logic [63:0]       rsp_rdata,
    input logic [FRAMES-1:0] match_vec,
    input logic [CNT_W-1:0]  pages_q
);
    logic misaligned;
    assign misaligned = (req_size == 2'd1 && req_addr[0]) ||
                        (req_size == 2'd2 && req_addr[1:0] != 2'b00) ||
                        (req_size == 2'd3 && req_addr[2:0] != 3'b000);

    assert_rsp_follows_R11: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_ready);
    assert_rsp_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_ready);
    assert_store_rsp_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |=> rsp_rdata == 64'd0);
    assert_misaligned_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && misaligned) |=> rsp_rdata == 64'd0);
    assert_byte_width_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_size == 2'd0) |=> rsp_rdata[63:8] == 56'd0);
    assert_unique_page_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match_vec));
    assert_budget_limit_R3: assert property (@(posedge clk) disable iff (rst)
        (pages_q == '0) || ((64'(pages_q) << 12) < LIMIT));
    assert_alloc_step_R3: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (pages_q == $past(pages_q) || pages_q == $past(pages_q) + 1'b1));
    assert_read_no_alloc_R2: assert property (@(posedge clk) disable iff (rst)
        (!req_valid || !req_write) |=> $stable(pages_q));
endmodule

bind sparse_page_mem spm_checker #(
    .ADDR_W(ADDR_W), .FRAMES(FRAMES), .CNT_W(CNT_W), .LIMIT(LIMIT)
) u_spm_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata),
    .match_vec (match_vec),
    .pages_q   (pages_q)
);

// File: tb/tb_sparse_page_mem.sv
module tb_sparse_page_mem;
    localparam int          AW = 32;
    localparam int          FR = 4;
    localparam logic [63:0] MB = 64'd12288;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = '0;
    logic [63:0]   req_wdata = '0;
    logic          rsp_ready;
    logic [63:0]   rsp_rdata;

    typedef struct {
        logic [63:0] data;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   total = 0, bad = 0;
    bit   finished = 0;

    always #4 clk = ~clk;

    sparse_page_mem #(.ADDR_W(AW), .FRAMES(FR), .MAX_BYTES(MB)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
    );

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic wr, input logic [AW-1:0] a, input logic [63:0] d,
                        input logic [1:0] sz, input logic [63:0] exp, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_size = sz;
        e.data = exp; e.tag = tag;
        q.push_back(e);
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    // monitor: pop one expected item for every response strobe
    always @(negedge clk) begin
        if (!rst && rsp_ready) begin
            if (q.size() == 0) begin
                check(64'd1, 64'd0, "R11 unexpected response");
            end else begin
                exp_t e;
                e = q.pop_front();
                check(rsp_rdata, e.data, e.tag);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL R11 watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check({63'd0, rsp_ready}, 64'd0, "R11 ready low after reset");
        check(rsp_rdata, 64'd0, "R11 data zero after reset");

        send(0, 32'h0000_1000, 64'd0, 2'd3, 64'd0, "R2 read unbacked");
        send(1, 32'h0000_1000, 64'd0, 2'd0, 64'd0, "R4 zero store rsp");
        send(0, 32'h0000_1000, 64'd0, 2'd0, 64'd0, "R4 zero store not backed");
        send(1, 32'h0000_5008, 64'h1122334455667788, 2'd3, 64'd0, "R11 store rsp zero");
        send(0, 32'h0000_5008, 64'd0, 2'd3, 64'h1122334455667788, "R3 alloc on store");
        send(0, 32'h0000_5008, 64'd0, 2'd0, 64'h88, "R7 byte read");
        send(0, 32'h0000_500A, 64'd0, 2'd1, 64'h5566, "R7 half read");
        send(0, 32'h0000_500C, 64'd0, 2'd2, 64'h11223344, "R7 word read");
        send(0, 32'h0000_5010, 64'd0, 2'd3, 64'd0, "R5 zero fill next word");
        send(0, 32'h0000_5000, 64'd0, 2'd3, 64'd0, "R5 zero fill prev word");
        send(1, 32'h0000_500D, 64'hAB, 2'd0, 64'd0, "R8 byte store rsp");
        send(0, 32'h0000_5008, 64'd0, 2'd3, 64'h1122AB4455667788, "R8 byte merge");
        send(1, 32'h0000_5009, 64'h00, 2'd0, 64'd0, "R8 zero store rsp");
        send(0, 32'h0000_5008, 64'd0, 2'd3, 64'h1122AB4455660088, "R8 zero store lands");
        send(1, 32'h0000_5009, 64'hFFFF, 2'd1, 64'd0, "R9 misaligned store rsp");
        send(0, 32'h0000_5008, 64'd0, 2'd3, 64'h1122AB4455660088, "R9 misaligned store ignored");
        send(0, 32'h0000_5009, 64'd0, 2'd1, 64'd0, "R9 misaligned read zero");
        send(0, 32'h0000_500C, 64'd0, 2'd3, 64'd0, "R9 misaligned wide read zero");
        send(1, 32'h0000_7001, 64'hFFFF, 2'd1, 64'd0, "R9 misaligned unbacked store");
        send(1, 32'hFFFF_9008, 64'hCAFE, 2'd3, 64'd0, "R1 high page store");
        send(0, 32'hFFFF_9008, 64'd0, 2'd3, 64'hCAFE, "R1 high page read");
        send(0, 32'h0000_5008, 64'd0, 2'd3, 64'h1122AB4455660088, "R1 pages independent");
        send(0, 32'h0000_7000, 64'd0, 2'd3, 64'd0, "R9 no alloc from misaligned");
        send(1, 32'h0000_A000, 64'h1, 2'd3, 64'd0, "R6 refused store rsp");
        send(0, 32'h0000_A000, 64'd0, 2'd3, 64'd0, "R6 refused store discarded R3 strict");
        send(1, 32'h0000_5008, 64'h5A, 2'd0, 64'd0, "R8 store hit after budget spent");
        send(0, 32'h0000_5008, 64'd0, 2'd0, 64'h5A, "R8 hit page still writable");
        idle();

        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check({63'd0, rsp_ready}, 64'd0, "R10 ready low after second reset");
        send(0, 32'h0000_5008, 64'd0, 2'd3, 64'd0, "R10 mapping gone");
        send(0, 32'hFFFF_9008, 64'd0, 2'd3, 64'd0, "R10 high mapping gone");
        send(1, 32'h0000_3008, 64'h77, 2'd0, 64'd0, "R5 realloc store rsp");
        send(0, 32'h0000_3008, 64'd0, 2'd3, 64'h77, "R5 stale frame reads zero");
        send(1, 32'h0000_4000, 64'h5, 2'd3, 64'd0, "R10 second alloc rsp");
        send(0, 32'h0000_4000, 64'd0, 2'd3, 64'h5, "R10 budget cleared");
        send(1, 32'h0000_6000, 64'h9, 2'd3, 64'd0, "R3 third alloc refused rsp");
        send(0, 32'h0000_6000, 64'd0, 2'd3, 64'd0, "R3 third alloc refused");
        idle();
        repeat (3) @(negedge clk);
        check(64'(q.size()), 64'd0, "R11 all responses seen");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule